// File: doc/BRIEF.md
# 32-by-16 Iterative Integer Divider

This unit divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement signed numbers. It uses restoring shift-and-subtract and makes one quotient bit per clock. A caller pulses `start` with the operands while the unit is idle. The unit then holds `busy` high until it pulses `done` for one cycle. In that same cycle it presents the packed result, the condition flags, a write-enable for the destination register, a divide-by-zero trap request and the instruction cost in cycles.

On success the packed result carries the remainder in bits 31:16 and the quotient in bits 15:0. Two kinds of operation end without a write. A quotient that does not fit in 16 bits is an overflow: the unit sets V and leaves the destination untouched. A zero divisor raises a trap request carrying a fixed vector number. The `result` port always shows the last value written, so a suppressed write appears at the port as an unchanged value.

Top module: `divider32x16`

## Requirements
- R1: In unsigned mode (`signedOp`=0) with a quotient below 65536, `done` comes with `writeEn`=1 and `result` = {remainder[15:0], quotient[15:0]}.
- R2: In signed mode (`signedOp`=1) the quotient truncates toward zero and the remainder takes the sign of the dividend. Both are packed as 16-bit two's-complement values in the same layout as R1.
- R3: In unsigned mode a quotient of 65536 or more sets V=1 and C=0 and keeps `writeEn`=0. `result`, N and Z keep their previous values.
- R4: In signed mode a quotient outside -32768..32767 is an overflow with the same effects as R3. The case 0x80000000 divided by -1 is among them and is caught before any iteration.
- R5: A zero divisor gives `done` with `trapReq`=1, `trapVector`=5 and `writeEn`=0, and leaves `result` and all four flags unchanged. `done` follows 2 clock edges after the edge that samples `start`.
- R6: On a successful division N equals bit 15 of the quotient, Z is 1 exactly when the quotient is zero, and V=C=0.
- R7: `cycleCost` reads 140 for unsigned and 158 for signed operations. A zero divisor adds 38 to that figure.
- R8: After reset `busy`, `done`, `result` and the flags are 0. `busy` rises on the edge that samples `start` and falls on the edge that raises `done`. `done` lasts one cycle.
- R9: A `start` pulse while `busy` is high is ignored. It does not alter the running operation and it produces no extra `done`.
- R10: An operation that runs the full iteration shows `done` 19 clock edges after the edge that samples `start`, counting that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| signedOp | input | 1 | 1 = signed division, 0 = unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Remainder (31:16) and quotient (15:0), last written value |
| writeEn | output | 1 | Destination write strobe, valid with done |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |
| trapReq | output | 1 | Divide-by-zero trap request, valid with done |
| trapVector | output | 8 | Trap vector number (5) |
| cycleCost | output | 8 | Instruction cost in cycles, valid from done |

## Verification
The hardest case is a signed overflow that only shows after all sixteen iterations. A magnitude quotient of exactly 32768 passes the early range check, but its sign then makes it unrepresentable. A dividend of 32768 divided by 1 reaches this path, while -32768 divided by 1 must still succeed. The bench runs both back to back and also runs 0x80000000 divided by -1 to cover the early path. For the ignored start, the bench drives a second `start` mid-iteration with different operands. It then checks that only the first operation's result appears and that the count of `done` pulses matches the operations issued.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIX  = 2'd3
  } divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands
    logic prep;   // magnitude/early checks, seed iteration
    logic step;   // one restoring step
    logic fix;    // sign correction and late overflow
  } divCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic zeroDiv;
    logic earlyOvf;
  } divStat_t;

endpackage

// File: rtl/div_step.sv
// One restoring shift-and-subtract step, purely combinational.
module div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] remIn,
  input  logic [W-1:0] quoIn,
  input  logic [W-1:0] divAbs,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quoOut
);
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         take;

  always_comb begin
    shifted = {remIn, quoIn[W-1]};
    diff    = {1'b0, shifted} - {2'b00, divAbs};
    take    = ~diff[W+1];
    remOut  = take ? diff[W-1:0] : shifted[W-1:0];
    quoOut  = {quoIn[W-2:0], take};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  divStat_t stat,
  output divCtl_t  ctl,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  divState_t        state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) state <= ST_PREP;
        ST_PREP: begin
          if (stat.zeroDiv || stat.earlyOvf) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(STEPS - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.prep = (state == ST_PREP);
    ctl.step = (state == ST_RUN);
    ctl.fix  = (state == ST_FIX);
    busy     = (state != ST_IDLE);
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int DIVISOR_W     = 16,
  parameter int COST_W        = 8,
  parameter int VEC_W         = 8,
  parameter int COST_UNSIGNED = 140,
  parameter int COST_SIGNED   = 158,
  parameter int COST_TRAP_ADD = 38,
  parameter int TRAP_VECTOR   = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  divCtl_t                ctl,
  input  logic                   signedIn,
  input  logic [2*DIVISOR_W-1:0] dividendIn,
  input  logic [DIVISOR_W-1:0]   divisorIn,
  output divStat_t               stat,
  output logic [2*DIVISOR_W-1:0] result,
  output logic                   writeEn,
  output logic                   flagN,
  output logic                   flagZ,
  output logic                   flagV,
  output logic                   flagC,
  output logic                   trapReq,
  output logic [VEC_W-1:0]       trapVector,
  output logic [COST_W-1:0]      cycleCost
);
  localparam int W  = DIVISOR_W;
  localparam int DW = 2 * DIVISOR_W;
  localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

  logic [DW-1:0] dividendR;
  logic [W-1:0]  divisorR;
  logic          signedR;

  logic          negDividend, negDivisor;
  logic [DW-1:0] absDividend;
  logic [W-1:0]  absDivisor;

  logic [W-1:0]  remR, quoR, divAbsR;
  logic          negQuoR, negRemR;
  logic [W-1:0]  remNext, quoNext;

  logic [W-1:0]  quoFinal, remFinal;
  logic          lateOvf;
  logic [COST_W-1:0] baseCost;

  // operand magnitudes and early checks
  always_comb begin
    negDividend   = signedR & dividendR[DW-1];
    negDivisor    = signedR & divisorR[W-1];
    absDividend   = negDividend ? (DW'(0) - dividendR) : dividendR;
    absDivisor    = negDivisor  ? (W'(0) - divisorR)   : divisorR;
    stat.zeroDiv  = (divisorR == '0);
    stat.earlyOvf = !stat.zeroDiv && (absDividend[DW-1:W] >= absDivisor);
    baseCost      = signedR ? COST_W'(COST_SIGNED) : COST_W'(COST_UNSIGNED);
  end

  div_step #(.W(W)) stepU (
    .remIn (remR),
    .quoIn (quoR),
    .divAbs(divAbsR),
    .remOut(remNext),
    .quoOut(quoNext)
  );

  // sign correction and representability of the final quotient
  always_comb begin
    quoFinal = negQuoR ? (W'(0) - quoR) : quoR;
    remFinal = negRemR ? (W'(0) - remR) : remR;
    if (!signedR)     lateOvf = 1'b0;
    else if (negQuoR) lateOvf = (quoR > MIN_MAG);
    else              lateOvf = quoR[W-1];
  end

  assign trapVector = VEC_W'(TRAP_VECTOR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dividendR <= '0;
      divisorR  <= '0;
      signedR   <= 1'b0;
      remR      <= '0;
      quoR      <= '0;
      divAbsR   <= '0;
      negQuoR   <= 1'b0;
      negRemR   <= 1'b0;
      result    <= '0;
      writeEn   <= 1'b0;
      trapReq   <= 1'b0;
      flagN     <= 1'b0;
      flagZ     <= 1'b0;
      flagV     <= 1'b0;
      flagC     <= 1'b0;
      cycleCost <= '0;
    end else begin
      writeEn <= 1'b0;
      trapReq <= 1'b0;
      if (ctl.load) begin
        dividendR <= dividendIn;
        divisorR  <= divisorIn;
        signedR   <= signedIn;
      end
      if (ctl.prep) begin
        if (stat.zeroDiv) begin
          trapReq   <= 1'b1;
          cycleCost <= baseCost + COST_W'(COST_TRAP_ADD);
        end else if (stat.earlyOvf) begin
          flagV     <= 1'b1;
          flagC     <= 1'b0;
          cycleCost <= baseCost;
        end else begin
          remR    <= absDividend[DW-1:W];
          quoR    <= absDividend[W-1:0];
          divAbsR <= absDivisor;
          negQuoR <= negDividend ^ negDivisor;
          negRemR <= negDividend;
        end
      end
      if (ctl.step) begin
        remR <= remNext;
        quoR <= quoNext;
      end
      if (ctl.fix) begin
        cycleCost <= baseCost;
        flagC     <= 1'b0;
        if (lateOvf) begin
          flagV <= 1'b1;
        end else begin
          result  <= {remFinal, quoFinal};
          writeEn <= 1'b1;
          flagN   <= quoFinal[W-1];
          flagZ   <= (quoFinal == '0);
          flagV   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/divider32x16.sv
module divider32x16
  import div_pkg::*;
#(
  parameter int DIVISOR_W     = 16,
  parameter int COST_W        = 8,
  parameter int VEC_W         = 8,
  parameter int COST_UNSIGNED = 140,
  parameter int COST_SIGNED   = 158,
  parameter int COST_TRAP_ADD = 38,
  parameter int TRAP_VECTOR   = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   signedOp,
  input  logic [2*DIVISOR_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]   divisor,
  output logic                   busy,
  output logic                   done,
  output logic [2*DIVISOR_W-1:0] result,
  output logic                   writeEn,
  output logic                   flagN,
  output logic                   flagZ,
  output logic                   flagV,
  output logic                   flagC,
  output logic                   trapReq,
  output logic [VEC_W-1:0]       trapVector,
  output logic [COST_W-1:0]      cycleCost
);
  divCtl_t  ctl;
  divStat_t stat;

  div_ctrl #(.STEPS(DIVISOR_W)) ctrlU (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  div_datapath #(
    .DIVISOR_W    (DIVISOR_W),
    .COST_W       (COST_W),
    .VEC_W        (VEC_W),
    .COST_UNSIGNED(COST_UNSIGNED),
    .COST_SIGNED  (COST_SIGNED),
    .COST_TRAP_ADD(COST_TRAP_ADD),
    .TRAP_VECTOR  (TRAP_VECTOR)
  ) dpU (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .signedIn  (signedOp),
    .dividendIn(dividend),
    .divisorIn (divisor),
    .stat      (stat),
    .result    (result),
    .writeEn   (writeEn),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagV     (flagV),
    .flagC     (flagC),
    .trapReq   (trapReq),
    .trapVector(trapVector),
    .cycleCost (cycleCost)
  );
endmodule

// File: rtl/divider32x16_chk.sv
module divider32x16_chk #(
  parameter int DIVISOR_W     = 16,
  parameter int COST_W        = 8,
  parameter int COST_UNSIGNED = 140,
  parameter int COST_SIGNED   = 158,
  parameter int COST_TRAP_ADD = 38
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [2*DIVISOR_W-1:0] result,
  input logic                   writeEn,
  input logic                   flagV,
  input logic                   flagC,
  input logic                   trapReq,
  input logic [COST_W-1:0]      cycleCost
);
  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));

  // R3
  no_overflow_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && flagV) |-> !writeEn);

  // R5
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (done && !writeEn));

  // R5
  trap_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (cycleCost == COST_W'(COST_UNSIGNED + COST_TRAP_ADD) ||
                 cycleCost == COST_W'(COST_SIGNED + COST_TRAP_ADD)));

  // R1
  write_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> (done && !flagV));

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !trapReq) |-> !flagC);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |-> $stable(result));
endmodule

bind divider32x16 divider32x16_chk #(
  .DIVISOR_W    (DIVISOR_W),
  .COST_W       (COST_W),
  .COST_UNSIGNED(COST_UNSIGNED),
  .COST_SIGNED  (COST_SIGNED),
  .COST_TRAP_ADD(COST_TRAP_ADD)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .writeEn  (writeEn),
  .flagV    (flagV),
  .flagC    (flagC),
  .trapReq  (trapReq),
  .cycleCost(cycleCost)
);

// File: tb/divider32x16_tb_top.sv
module divider32x16_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedOp = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, writeEn, flagN, flagZ, flagV, flagC, trapReq;
  logic [31:0] result;
  logic [7:0]  trapVector, cycleCost;

  always #10 clk = ~clk; // 50 MHz

  divider32x16 dut_i (
    .clk(clk), .rstN(rstN), .start(start), .signedOp(signedOp),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .writeEn(writeEn), .flagN(flagN), .flagZ(flagZ),
    .flagV(flagV), .flagC(flagC), .trapReq(trapReq),
    .trapVector(trapVector), .cycleCost(cycleCost)
  );

  typedef struct {
    logic [31:0] res;
    logic        wr, n, z, v, c, trap;
    logic [7:0]  cost;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  int   doneSeen = 0;
  int   issued = 0;

  // reference model state (what the ports should hold)
  logic [31:0] mRes = '0;
  logic mN = 0, mZ = 0, mV = 0, mC = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [15:0] b,
                                 input logic sgn, input string tag);
    exp_t e;
    longint q, r;
    logic ovf;
    e.tag  = tag;
    e.trap = 1'b0;
    e.wr   = 1'b0;
    e.cost = sgn ? 8'd158 : 8'd140;
    if (b == 16'd0) begin
      e.trap = 1'b1;
      e.cost = e.cost + 8'd38;
    end else begin
      if (sgn) begin
        q = longint'($signed(a)) / longint'($signed(b));
        r = longint'($signed(a)) % longint'($signed(b));
        ovf = (q > 32767) || (q < -32768);
      end else begin
        q = longint'({32'd0, a}) / longint'({48'd0, b});
        r = longint'({32'd0, a}) % longint'({48'd0, b});
        ovf = (q > 65535);
      end
      if (ovf) begin
        mV = 1'b1; mC = 1'b0;
      end else begin
        mRes = {r[15:0], q[15:0]};
        mN = q[15]; mZ = (q[15:0] == 16'd0); mV = 1'b0; mC = 1'b0;
        e.wr = 1'b1;
      end
    end
    e.res = mRes; e.n = mN; e.z = mZ; e.v = mV; e.c = mC;
    return e;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        doneSeen++;
        if (expQ.size() == 0) begin
          chk("R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(e.tag, "writeEn", {31'd0, writeEn}, {31'd0, e.wr});
          chk(e.tag, "result", result, e.res);
          chk(e.tag, "NZVC", {28'd0, flagN, flagZ, flagV, flagC},
              {28'd0, e.n, e.z, e.v, e.c});
          chk(e.tag, "trapReq", {31'd0, trapReq}, {31'd0, e.trap});
          if (e.trap) chk(e.tag, "trapVector", {24'd0, trapVector}, 32'd5);
          chk(e.tag, "cycleCost", {24'd0, cycleCost}, {24'd0, e.cost});
          chk("R8", "busy with done", {31'd0, busy}, 32'd0);
        end
      end
    end
  end

  task automatic runOp(input logic [31:0] a, input logic [15:0] b,
                       input logic sgn, input string tag, input int expLat);
    int n;
    while (busy) @(negedge clk);
    expQ.push_back(model(a, b, sgn, tag));
    issued++;
    dividend = a; divisor = b; signedOp = sgn; start = 1'b1;
    n = 0;
    @(posedge clk); n++;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    if (expLat > 0) chk(tag, "latency", n, expLat);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=timeout exp=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
    chk("R8", "reset result", result, 32'd0);
    chk("R8", "reset flags", {28'd0, flagN, flagZ, flagV, flagC}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 unsigned
    runOp(32'd100000, 16'd7, 1'b0, "R1", 19);          // R10
    runOp(32'h0000FFFF, 16'd1, 1'b0, "R1", 0);          // N set
    runOp(32'hFFFEFFFF, 16'hFFFF, 1'b0, "R1", 0);
    // R6 zero quotient
    runOp(32'd5, 16'd7, 1'b0, "R6", 0);
    runOp(32'd0, 16'd5, 1'b1, "R6", 0);
    // R3 unsigned overflow
    runOp(32'h00010000, 16'd1, 1'b0, "R3", 2);
    runOp(32'hFFFFFFFF, 16'd2, 1'b0, "R3", 0);
    // R2 signed
    runOp(-32'sd100001, 16'd7, 1'b1, "R2", 19);         // R10
    runOp(32'd100001, -16'sd7, 1'b1, "R2", 0);
    runOp(-32'sd100001, -16'sd7, 1'b1, "R2", 0);
    runOp(32'hFFFF8000, 16'd1, 1'b1, "R2", 0);          // -32768 fits
    // R4 signed overflow
    runOp(32'h80000000, 16'hFFFF, 1'b1, "R4", 2);
    runOp(32'd32768, 16'd1, 1'b1, "R4", 19);            // late overflow
    runOp(32'hFFFF7FFF, 16'd1, 1'b1, "R4", 0);          // -32769
    // R5 zero divisor, both modes (R7 cost)
    runOp(32'd1234, 16'd0, 1'b0, "R5", 2);
    runOp(32'd1234, 16'd0, 1'b1, "R5", 2);
    runOp(32'd60000, 16'd3, 1'b0, "R7", 0);

    // R9 start while busy is ignored
    while (busy) @(negedge clk);
    expQ.push_back(model(32'd9999, 16'd10, 1'b0, "R9"));
    issued++;
    dividend = 32'd9999; divisor = 16'd10; signedOp = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    dividend = 32'd77; divisor = 16'd0; signedOp = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R9", "done count", doneSeen, issued);
    chk("R9", "idle after", {31'd0, busy}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule